// File: doc/BRIEF.md
# Windowed PWM Excitation Sequencer

This block drives a piezoelectric transmitter with a short burst of complementary pulse-width-modulated pulses. It runs on a programmable carrier clock. Each carrier cycle of the burst is one frame of two equal halves. An up-side pulse starts the first half and a down-side pulse starts the second half. The width of each pulse, counted in clock periods, comes from a small fixed code table. After off-chip low-pass filtering, the differential pair approximates a sinusoid shaped by a window, five carrier cycles long.

A one-cycle start request launches the burst, provided the block is idle and enabled. The block then walks its table index once per frame and wraps after the last entry. It stops after the set number of frames and signals completion with a single-cycle done flag. Dropping the enable at any time returns the block to idle at once.

Top module: `pwm_burst_seq`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, drv_up, drv_dn, busy and done are all low.
- R2: A start that is high at a rising edge while busy is low and enable is high is accepted. busy rises one cycle after that edge, and the first up pulse begins in the same cycle that busy rises.
- R3: In frame k of a burst (k counted from 0), drv_up is high for the first W cycles of the frame, where W is 1, 5, 7, 3 for k mod 4 = 0, 1, 2, 3.
- R4: In frame k, drv_dn is high for W cycles starting at cycle HALF_LEN (8) of the frame, where W is 3, 7, 5, 1 for k mod 4 = 0, 1, 2, 3. This is the up sequence in reverse order.
- R5: drv_up and drv_dn are never high together, and both are low whenever busy is low.
- R6: A burst is 5 frames of 2*HALF_LEN = 16 cycles, so busy stays high for exactly 80 cycles. The fifth frame reuses table entry 0. Over one burst, drv_up is high for 17 cycles and drv_dn for 19 cycles.
- R7: done is high for exactly one cycle, in the cycle after the last busy cycle, and never while busy is high.
- R8: A start that arrives while busy is high, or in the cycle between acceptance and busy rising, has no effect. A start in the done cycle is accepted.
- R9: enable low at a rising edge sends the block to idle in the next cycle, with no done pulse. A start is ignored while enable is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Carrier (synthesizer) clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Burst launch request |
| enable | input | 1 | Block enable; low aborts and holds idle |
| drv_up | output | 1 | Up-side pulse drive |
| drv_dn | output | 1 | Down-side pulse drive |
| busy | output | 1 | High while a burst is being emitted |
| done | output | 1 | One-cycle pulse at burst completion |

## Verification
The first stimulus is a single isolated start. It checks the absolute timing of each pulse edge against the table and shows whether the index wraps into the fifth frame. The second adds repeated start pulses during a burst, which separates correct request masking from a restart that would stretch busy beyond 80 cycles. Holding start high across the end of a burst tests acceptance in the done cycle and shows the gap between bursts. The remaining cases drop enable in mid-burst, request a start while disabled, and reset in mid-burst; together they cover both ways a burst can end early.

// File: rtl/pwm_burst_pkg.sv
package pwm_burst_pkg;

    localparam int unsigned PWM_CODE_W = 4;

    // Up-side width codes; the down side reads the same list in reverse order.
    function automatic logic [PWM_CODE_W-1:0] pwm_up_code(input int unsigned slot);
        logic [PWM_CODE_W-1:0] code;
        case (slot % 4)
            0:       code = 4'd1;
            1:       code = 4'd5;
            2:       code = 4'd7;
            default: code = 4'd3;
        endcase
        return code;
    endfunction

endpackage

// File: rtl/pwm_width_rom.sv
module pwm_width_rom
    import pwm_burst_pkg::*;
#(
    parameter int unsigned N_ENT = 4,
    parameter int unsigned CW    = 4,
    localparam int unsigned IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
    input  logic [IDX_W-1:0] idx,
    output logic [CW-1:0]    up_w,
    output logic [CW-1:0]    dn_w
);

    logic [CW-1:0] up_tab [N_ENT];
    logic [CW-1:0] dn_tab [N_ENT];

    for (genvar g = 0; g < N_ENT; g++) begin : g_tab
        assign up_tab[g] = CW'(pwm_up_code(g));
        assign dn_tab[g] = CW'(pwm_up_code(N_ENT - 1 - g));
    end

    assign up_w = up_tab[idx];
    assign dn_w = dn_tab[idx];

endmodule

// File: rtl/pwm_width_cmp.sv
module pwm_width_cmp #(
    parameter int unsigned CW = 4
) (
    input  logic          active,
    input  logic [CW-1:0] cnt,
    input  logic [CW-1:0] width,
    input  logic          held,
    output logic          level
);

    // A pulse opens at count zero and closes when the count reaches the width.
    assign level = active & ((cnt == '0) | held) & (cnt != width);

endmodule

// File: rtl/pwm_drive_split.sv
module pwm_drive_split (
    input  logic level,
    input  logic phase,
    output logic up,
    output logic dn
);

    logic shadow;

    // The second-half copy is steered to the down side; XOR removes it from the up side.
    assign shadow = level & phase;
    assign dn     = shadow;
    assign up     = level ^ shadow;

endmodule

// File: rtl/pwm_burst_seq.sv
module pwm_burst_seq #(
    parameter int unsigned N_ENT    = 4,
    parameter int unsigned CW       = 4,
    parameter int unsigned HALF_LEN = 8,
    parameter int unsigned N_CYC    = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic enable,
    output logic drv_up,
    output logic drv_dn,
    output logic busy,
    output logic done
);

    localparam int unsigned IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1;
    localparam int unsigned CYC_W = (N_CYC > 1) ? $clog2(N_CYC) : 1;
    localparam logic [CW-1:0]    CNT_LAST = CW'(HALF_LEN - 1);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(N_ENT - 1);
    localparam logic [CYC_W-1:0] CYC_LAST = CYC_W'(N_CYC - 1);

    typedef struct packed {
        logic             active;
        logic             half;
        logic [CW-1:0]    cnt;
        logic [IDX_W-1:0] idx;
        logic [CYC_W-1:0] cyc;
        logic             up;
        logic             dn;
        logic             busy;
        logic             done;
    } seq_st_t;

    seq_st_t st_d, st_q;

    logic [CW-1:0] up_w, dn_w, w_sel;
    logic          lvl_now, up_now, dn_now;

    pwm_width_rom #(.N_ENT(N_ENT), .CW(CW)) u_rom (
        .idx  (st_q.idx),
        .up_w (up_w),
        .dn_w (dn_w)
    );

    assign w_sel = st_q.half ? dn_w : up_w;

    pwm_width_cmp #(.CW(CW)) u_cmp (
        .active (st_q.active),
        .cnt    (st_q.cnt),
        .width  (w_sel),
        .held   (st_q.up | st_q.dn),
        .level  (lvl_now)
    );

    pwm_drive_split u_split (
        .level (lvl_now),
        .phase (st_q.half),
        .up    (up_now),
        .dn    (dn_now)
    );

    always_comb begin
        st_d      = st_q;
        st_d.up   = up_now;
        st_d.dn   = dn_now;
        st_d.busy = st_q.active;
        st_d.done = st_q.busy & ~st_q.active;

        if (st_q.active) begin
            if (st_q.cnt == CNT_LAST) begin
                st_d.cnt  = '0;
                st_d.half = ~st_q.half;
                if (st_q.half) begin
                    st_d.idx = (st_q.idx == IDX_LAST) ? '0 : st_q.idx + 1'b1;
                    if (st_q.cyc == CYC_LAST) begin
                        st_d.active = 1'b0;
                        st_d.cyc    = '0;
                        st_d.idx    = '0;
                    end else begin
                        st_d.cyc = st_q.cyc + 1'b1;
                    end
                end
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end else if (start && !st_q.busy) begin
            st_d.active = 1'b1;
            st_d.half   = 1'b0;
            st_d.cnt    = '0;
            st_d.idx    = '0;
            st_d.cyc    = '0;
        end

        if (!enable) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign drv_up = st_q.up;
    assign drv_dn = st_q.dn;
    assign busy   = st_q.busy;
    assign done   = st_q.done;

endmodule

// File: rtl/pwm_burst_seq_chk.sv
module pwm_burst_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic enable,
    input logic drv_up,
    input logic drv_dn,
    input logic busy,
    input logic done
);

    // R5
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(drv_up && drv_dn));

    // R5
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!drv_up && !drv_dn));

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    // R9
    abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!busy && !done));

    // R2
    launch_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start, 2));

endmodule

bind pwm_burst_seq pwm_burst_seq_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .enable (enable),
    .drv_up (drv_up),
    .drv_dn (drv_dn),
    .busy   (busy),
    .done   (done)
);

// File: tb/pwm_burst_seq_bench.sv
module pwm_burst_seq_bench;

    logic clk = 1'b0;
    logic rst_n;
    logic start;
    logic enable;
    logic drv_up, drv_dn, busy, done;

    always #4 clk = ~clk;

    pwm_burst_seq u_pwm_burst_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .enable (enable),
        .drv_up (drv_up),
        .drv_dn (drv_dn),
        .busy   (busy),
        .done   (done)
    );

    int n_checks = 0;
    int n_errors = 0;
    int up_seq [4] = '{1, 5, 7, 3};
    int dn_seq [4] = '{3, 7, 5, 1};

    // Reference model: position t inside the visible burst, -1 when idle.
    int t = -1;
    bit pend = 0;
    bit done_e = 0;
    bit started = 0;

    int cnt_up = 0, cnt_dn = 0, cnt_busy = 0, cnt_done = 0;

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        started = 1;
        done_e  = 0;
        if (!rst_n || !enable) begin
            t    = -1;
            pend = 0;
        end else if (t >= 0) begin
            if (t == 79) begin
                t      = -1;
                done_e = 1;
            end else begin
                t++;
            end
        end else if (pend) begin
            t    = 0;
            pend = 0;
        end else if (start) begin
            pend = 1;
        end
    end

    always @(negedge clk) begin
        if (started && rst_n) begin
            int up_e, dn_e;
            up_e = 0;
            dn_e = 0;
            if (t >= 0) begin
                int frame, hf, c, w;
                frame = t / 16;
                hf    = (t / 8) % 2;
                c     = t % 8;
                w     = hf ? dn_seq[frame % 4] : up_seq[frame % 4];
                up_e  = (hf == 0 && c < w) ? 1 : 0;
                dn_e  = (hf == 1 && c < w) ? 1 : 0;
            end
            check("R3 drv_up", drv_up, up_e);
            check("R4 drv_dn", drv_dn, dn_e);
            check("R6 busy", busy, (t >= 0) ? 1 : 0);
            check("R7 done", done, done_e);
            check("R5 overlap", drv_up & drv_dn, 0);
            cnt_up   += drv_up;
            cnt_dn   += drv_dn;
            cnt_busy += busy;
            cnt_done += done;
        end
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic clear_counts();
        cnt_up = 0; cnt_dn = 0; cnt_busy = 0; cnt_done = 0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; start = 1'b0; enable = 1'b0;
        step(4);
        check("R1 up in reset", drv_up, 0);
        check("R1 busy in reset", busy, 0);
        rst_n = 1'b1;
        step(1);
        check("R1 dn after reset", drv_dn, 0);
        check("R1 done after reset", done, 0);
        enable = 1'b1;
        step(2);

        // Single isolated burst
        clear_counts();
        start = 1'b1; step(1); start = 1'b0;
        check("R2 busy not yet", busy, 0);
        step(1);
        check("R2 busy risen", busy, 1);
        check("R2 first up pulse", drv_up, 1);
        step(85);
        check("R6 up total", cnt_up, 17);
        check("R6 dn total", cnt_dn, 19);
        check("R6 busy length", cnt_busy, 80);
        check("R7 one done", cnt_done, 1);

        // Starts during a burst are masked
        clear_counts();
        start = 1'b1; step(1); start = 1'b0;
        start = 1'b1; step(1); start = 1'b0;
        step(20);
        start = 1'b1; step(3); start = 1'b0;
        step(30);
        start = 1'b1; step(1); start = 1'b0;
        step(40);
        check("R8 busy not stretched", cnt_busy, 80);
        check("R8 single done", cnt_done, 1);

        // Start held high across the done cycle
        clear_counts();
        start = 1'b1; step(100); start = 1'b0;
        step(100);
        check("R8 back to back busy", cnt_busy, 160);
        check("R8 back to back done", cnt_done, 2);

        // Abort with enable
        clear_counts();
        start = 1'b1; step(1); start = 1'b0;
        step(30);
        enable = 1'b0;
        step(1);
        check("R9 abort busy", busy, 0);
        start = 1'b1; step(5);
        check("R9 start ignored disabled", busy, 0);
        start = 1'b0;
        enable = 1'b1;
        step(5);
        check("R9 stays idle", busy, 0);
        check("R9 no done on abort", cnt_done, 0);

        // Reset in mid-burst
        start = 1'b1; step(1); start = 1'b0;
        step(20);
        rst_n = 1'b0;
        step(2);
        check("R1 mid reset up", drv_up | drv_dn, 0);
        check("R1 mid reset busy", busy, 0);
        rst_n = 1'b1;
        step(3);
        check("R1 idle after reset", busy, 0);

        finish_run();
    end

endmodule